// File: doc/BRIEF.md
# Per-Channel Waveform Gain and Offset Stage

This block sits after a multi-channel sine source. Each cycle it may accept one signed full-scale sample with a channel number and a user sideband word. It looks up that channel's gain and level shift in an on-block coefficient table. The gain is an unsigned fraction strictly below one. The level shift is a signed whole number. The block scales the sample by the gain, adds the shift at the integer binary point, and discards all fraction bits. It then presents the signed integer result with the same channel number and sideband word on an output stream. That stream has a valid strobe and no back-pressure.

The coefficient table has one 32-bit word per channel. It is filled through a simple synchronous write port, and every channel is programmed independently. The arithmetic runs in three registered steps: coefficient lookup, multiply, then add and drop fractions. A new sample can enter on every cycle.

Top module: `wave_scale_offset`

## Requirements
- R1: Reset drives out_valid, out_value, out_id and out_user to zero and clears every coefficient entry to gain 0 and shift 0, so a sample on an unprogrammed channel yields 0.
- R2: A sample accepted with in_valid high at a clock edge appears with out_valid high after exactly three edges. Samples on consecutive cycles give outputs on consecutive cycles, one output per input and in order.
- R3: out_id and out_user equal the in_id and in_user that were accepted with the sample, delayed by the same three edges.
- R4: out_value equals floor(sample * gain / 2^SCALE_W) + shift. The sample is signed two's complement. The gain is unsigned and sits in word bits [SCALE_W-1:0]. The shift is signed and sits in bits [SCALE_W+OFFS_W-1:SCALE_W] of the table word for in_id.
- R5: Dropping the fraction rounds toward negative infinity, so negative products with a nonzero fraction round down (for example, -3 with gain 0x8000 gives -2).
- R6: The table holds 2^ID_W independent entries indexed by channel. A write at cfg_addr changes only that channel.
- R7: Word bits at and above SCALE_W+OFFS_W are ignored.
- R8: A write takes effect for samples accepted on later edges. A sample accepted on the same edge as a write to its channel uses the previous entry.
- R9: While out_valid is low, out_value, out_id and out_user hold their last values.
- R10: out_value is max(SAMPLE_W, OFFS_W)+1 bits wide and carries the exact result at the extreme sample, gain and shift values without wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Coefficient table write strobe |
| cfg_addr | input | ID_W | Channel whose entry is written |
| cfg_wdata | input | 32 | Packed gain and shift word |
| in_valid | input | 1 | Input sample strobe |
| in_sample | input | SAMPLE_W | Signed full-scale sample |
| in_id | input | ID_W | Channel number of the sample |
| in_user | input | USER_W | Sideband word carried with the sample |
| out_valid | output | 1 | Output result strobe |
| out_value | output | max(SAMPLE_W,OFFS_W)+1 | Signed integer result |
| out_id | output | ID_W | Channel number of the result |
| out_user | output | USER_W | Sideband word of the result |

## Verification
The latency, pass-through and hold properties assume that in_valid is low for as long as reset is asserted. The bench holds in_valid and cfg_we at zero throughout its reset phase and changes inputs only on falling edges. The range properties on the product and on the result minus the shift rely only on the gain being a fraction below one. Any table word satisfies this, so the stimulus can use the extreme gain 0xFFFF and the most negative sample.

// File: rtl/wso_pkg.sv
package wso_pkg;
  localparam int CFG_W = 32;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int out_width(input int sample_w, input int offs_w);
    return imax(sample_w, offs_w) + 1;
  endfunction

  function automatic int prod_width(input int sample_w, input int scale_w);
    return sample_w + scale_w + 1;
  endfunction
endpackage

// File: rtl/wso_coef_table.sv
module wso_coef_table
  import wso_pkg::*;
#(
  parameter int ID_W    = 8,
  parameter int SCALE_W = 16,
  parameter int OFFS_W  = 12
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic [ID_W-1:0]          wr_addr,
  input  logic [CFG_W-1:0]         wr_word,
  input  logic [ID_W-1:0]          rd_addr,
  output logic [SCALE_W-1:0]       rd_scale,
  output logic signed [OFFS_W-1:0] rd_offs
);
  localparam int DEPTH   = 1 << ID_W;
  localparam int FIELD_W = SCALE_W + OFFS_W;

  function automatic logic [SCALE_W-1:0] gain_of(input logic [CFG_W-1:0] w);
    return w[SCALE_W-1:0];
  endfunction

  function automatic logic signed [OFFS_W-1:0] shift_of(input logic [CFG_W-1:0] w);
    return $signed(w[FIELD_W-1:SCALE_W]);
  endfunction

  logic [SCALE_W-1:0]       gain_mem  [DEPTH];
  logic signed [OFFS_W-1:0] shift_mem [DEPTH];

  generate
    if (FIELD_W < CFG_W) begin : g_spare
      logic unused_spare_bits;
      assign unused_spare_bits = ^wr_word[CFG_W-1:FIELD_W];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int e = 0; e < DEPTH; e++) begin
        gain_mem[e]  <= '0;
        shift_mem[e] <= '0;
      end
    end else if (wr_en) begin
      gain_mem[wr_addr]  <= gain_of(wr_word);
      shift_mem[wr_addr] <= shift_of(wr_word);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_scale <= '0;
      rd_offs  <= '0;
    end else begin
      rd_scale <= gain_mem[rd_addr];
      rd_offs  <= shift_mem[rd_addr];
    end
  end
endmodule

// File: rtl/wso_mul_stage.sv
module wso_mul_stage
  import wso_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int SCALE_W  = 16,
  parameter int OFFS_W   = 12,
  parameter int ID_W     = 8,
  parameter int USER_W   = 4
) (
  input  logic                                              clk,
  input  logic                                              rst,
  input  logic                                              i_valid,
  input  logic signed [SAMPLE_W-1:0]                        i_sample,
  input  logic [SCALE_W-1:0]                                i_scale,
  input  logic signed [OFFS_W-1:0]                          i_offs,
  input  logic [ID_W-1:0]                                   i_id,
  input  logic [USER_W-1:0]                                 i_user,
  output logic                                              o_valid,
  output logic signed [prod_width(SAMPLE_W, SCALE_W)-1:0]   o_prod,
  output logic signed [OFFS_W-1:0]                          o_offs,
  output logic [ID_W-1:0]                                   o_id,
  output logic [USER_W-1:0]                                 o_user
);
  localparam int PROD_W = prod_width(SAMPLE_W, SCALE_W);
  localparam logic signed [PROD_W-1:0] P_HI =
    PROD_W'(((64'sd1 <<< (SAMPLE_W-1)) - 64'sd1) * ((64'sd1 <<< SCALE_W) - 64'sd1));
  localparam logic signed [PROD_W-1:0] P_LO =
    PROD_W'(-(64'sd1 <<< (SAMPLE_W-1)) * ((64'sd1 <<< SCALE_W) - 64'sd1));

  function automatic logic signed [PROD_W-1:0] scaled_product(
    input logic signed [SAMPLE_W-1:0] s,
    input logic [SCALE_W-1:0]         g
  );
    logic signed [PROD_W-1:0] s_ext;
    logic signed [PROD_W-1:0] g_ext;
    s_ext = PROD_W'(s);
    g_ext = PROD_W'($signed({1'b0, g}));
    return s_ext * g_ext;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      o_valid <= 1'b0;
      o_prod  <= '0;
      o_offs  <= '0;
      o_id    <= '0;
      o_user  <= '0;
    end else begin
      o_valid <= i_valid;
      if (i_valid) begin
        o_prod <= scaled_product(i_sample, i_scale);
        o_offs <= i_offs;
        o_id   <= i_id;
        o_user <= i_user;
      end
    end
  end

  logic prod_in_range;
  assign prod_in_range = (o_prod <= P_HI) && (o_prod >= P_LO);

  // R4
  prod_bound_chk: assert property (@(posedge clk) disable iff (rst)
    o_valid |-> prod_in_range);
endmodule

// File: rtl/wso_sum_stage.sv
module wso_sum_stage
  import wso_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int SCALE_W  = 16,
  parameter int OFFS_W   = 12,
  parameter int ID_W     = 8,
  parameter int USER_W   = 4
) (
  input  logic                                             clk,
  input  logic                                             rst,
  input  logic                                             i_valid,
  input  logic signed [prod_width(SAMPLE_W, SCALE_W)-1:0]  i_prod,
  input  logic signed [OFFS_W-1:0]                         i_offs,
  input  logic [ID_W-1:0]                                  i_id,
  input  logic [USER_W-1:0]                                i_user,
  output logic                                             o_valid,
  output logic signed [out_width(SAMPLE_W, OFFS_W)-1:0]    o_value,
  output logic [ID_W-1:0]                                  o_id,
  output logic [USER_W-1:0]                                o_user
);
  localparam int PROD_W = prod_width(SAMPLE_W, SCALE_W);
  localparam int OUT_W  = out_width(SAMPLE_W, OFFS_W);
  localparam int SUM_W  = imax(PROD_W, OFFS_W + SCALE_W) + 1;
  localparam logic signed [OUT_W-1:0] R_HI = OUT_W'((64'sd1 <<< (SAMPLE_W-1)) - 64'sd1);
  localparam logic signed [OUT_W-1:0] R_LO = OUT_W'(-(64'sd1 <<< (SAMPLE_W-1)));

  function automatic logic signed [OUT_W-1:0] add_and_drop(
    input logic signed [PROD_W-1:0] p,
    input logic signed [OFFS_W-1:0] k
  );
    logic signed [SUM_W-1:0] k_al;
    logic signed [SUM_W-1:0] acc;
    k_al = SUM_W'(k) <<< SCALE_W;
    acc  = SUM_W'(p) + k_al;
    acc  = acc >>> SCALE_W;
    return OUT_W'(acc);
  endfunction

  logic signed [OFFS_W-1:0] shift_seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      o_valid    <= 1'b0;
      o_value    <= '0;
      o_id       <= '0;
      o_user     <= '0;
      shift_seen <= '0;
    end else begin
      o_valid <= i_valid;
      if (i_valid) begin
        o_value    <= add_and_drop(i_prod, i_offs);
        o_id       <= i_id;
        o_user     <= i_user;
        shift_seen <= i_offs;
      end
    end
  end

  logic signed [OUT_W-1:0] scaled_part;
  assign scaled_part = o_value - OUT_W'(shift_seen);

  // R5
  scaled_part_range_chk: assert property (@(posedge clk) disable iff (rst)
    o_valid |-> (scaled_part <= R_HI) && (scaled_part >= R_LO));

  // R9
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !o_valid |-> $stable(o_value) && $stable(o_id) && $stable(o_user));
endmodule

// File: rtl/wave_scale_offset.sv
module wave_scale_offset
  import wso_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int SCALE_W  = 16,
  parameter int OFFS_W   = 12,
  parameter int ID_W     = 8,
  parameter int USER_W   = 4
) (
  input  logic                                          clk,
  input  logic                                          rst,
  input  logic                                          cfg_we,
  input  logic [ID_W-1:0]                               cfg_addr,
  input  logic [CFG_W-1:0]                              cfg_wdata,
  input  logic                                          in_valid,
  input  logic signed [SAMPLE_W-1:0]                    in_sample,
  input  logic [ID_W-1:0]                               in_id,
  input  logic [USER_W-1:0]                             in_user,
  output logic                                          out_valid,
  output logic signed [out_width(SAMPLE_W, OFFS_W)-1:0] out_value,
  output logic [ID_W-1:0]                               out_id,
  output logic [USER_W-1:0]                             out_user
);
  localparam int PROD_W = prod_width(SAMPLE_W, SCALE_W);

  logic                       lk_valid;
  logic signed [SAMPLE_W-1:0] lk_sample;
  logic [ID_W-1:0]            lk_id;
  logic [USER_W-1:0]          lk_user;
  logic [SCALE_W-1:0]         lk_scale;
  logic signed [OFFS_W-1:0]   lk_offs;

  logic                       mu_valid;
  logic signed [PROD_W-1:0]   mu_prod;
  logic signed [OFFS_W-1:0]   mu_offs;
  logic [ID_W-1:0]            mu_id;
  logic [USER_W-1:0]          mu_user;

  wso_coef_table #(.ID_W(ID_W), .SCALE_W(SCALE_W), .OFFS_W(OFFS_W)) table_i (
    .clk(clk), .rst(rst),
    .wr_en(cfg_we), .wr_addr(cfg_addr), .wr_word(cfg_wdata),
    .rd_addr(in_id), .rd_scale(lk_scale), .rd_offs(lk_offs)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      lk_valid  <= 1'b0;
      lk_sample <= '0;
      lk_id     <= '0;
      lk_user   <= '0;
    end else begin
      lk_valid <= in_valid;
      if (in_valid) begin
        lk_sample <= in_sample;
        lk_id     <= in_id;
        lk_user   <= in_user;
      end
    end
  end

  wso_mul_stage #(.SAMPLE_W(SAMPLE_W), .SCALE_W(SCALE_W), .OFFS_W(OFFS_W),
                  .ID_W(ID_W), .USER_W(USER_W)) mul_i (
    .clk(clk), .rst(rst),
    .i_valid(lk_valid), .i_sample(lk_sample), .i_scale(lk_scale), .i_offs(lk_offs),
    .i_id(lk_id), .i_user(lk_user),
    .o_valid(mu_valid), .o_prod(mu_prod), .o_offs(mu_offs), .o_id(mu_id), .o_user(mu_user)
  );

  wso_sum_stage #(.SAMPLE_W(SAMPLE_W), .SCALE_W(SCALE_W), .OFFS_W(OFFS_W),
                  .ID_W(ID_W), .USER_W(USER_W)) sum_i (
    .clk(clk), .rst(rst),
    .i_valid(mu_valid), .i_prod(mu_prod), .i_offs(mu_offs), .i_id(mu_id), .i_user(mu_user),
    .o_valid(out_valid), .o_value(out_value), .o_id(out_id), .o_user(out_user)
  );

  logic [1:0] edges_since_rst;
  always_ff @(posedge clk) begin
    if (rst) edges_since_rst <= '0;
    else if (edges_since_rst != 2'd3) edges_since_rst <= edges_since_rst + 2'd1;
  end

  logic pipe_full;
  assign pipe_full = (edges_since_rst == 2'd3);

  // R2
  latency_three_chk: assert property (@(posedge clk) disable iff (rst)
    pipe_full |-> (out_valid == $past(in_valid, 3)));

  // R3
  sideband_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (pipe_full && out_valid) |-> (out_id == $past(in_id, 3)) && (out_user == $past(in_user, 3)));
endmodule

// File: tb/wave_scale_offset_tb.sv
module wave_scale_offset_tb_top;
  localparam int SAMPLE_W = 16;
  localparam int SCALE_W  = 16;
  localparam int OFFS_W   = 12;
  localparam int ID_W     = 8;
  localparam int USER_W   = 4;
  localparam int OUT_W    = 17;
  localparam int NV       = 8;

  typedef struct packed {
    logic [7:0]  id;
    logic [31:0] word;
    logic [15:0] smp;
    logic [3:0]  usr;
    int          ev;
    logic [15:0] tag;
  } vec_t;

  // word = {spare4, shift12, gain16}
  localparam vec_t VECS [NV] = '{
    '{8'd3,   {4'h0, 12'd10,  16'h8000},  16'd1000,   4'd1, 510,    "R4"},
    '{8'd7,   {4'h0, 12'd0,   16'h4000}, -16'sd1000,  4'd2, -250,   "R4"},
    '{8'd200, {4'hF, 12'h800, 16'hFFFF},  16'd32767,  4'd3, 30718,  "R7"},
    '{8'd255, {4'hA, 12'h800, 16'hFFFF},  16'h8000,   4'd4, -34816, "R10"},
    '{8'd0,   {4'h0, 12'd2047, 16'h0000}, 16'd12345,  4'd5, 2047,   "R4"},
    '{8'd9,   {4'h0, 12'd0,   16'h8000}, -16'sd3,     4'd6, -2,     "R5"},
    '{8'd10,  {4'h0, 12'hFFF, 16'h8000},  16'd3,      4'd7, 0,      "R5"},
    '{8'd11,  {4'h0, 12'd100, 16'h0001}, -16'sd1,     4'd8, 99,     "R5"}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we = 1'b0;
  logic [ID_W-1:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic in_valid = 1'b0;
  logic signed [SAMPLE_W-1:0] in_sample = '0;
  logic [ID_W-1:0] in_id = '0;
  logic [USER_W-1:0] in_user = '0;
  logic out_valid;
  logic signed [OUT_W-1:0] out_value;
  logic [ID_W-1:0] out_id;
  logic [USER_W-1:0] out_user;

  always #4 clk = ~clk;

  wave_scale_offset #(.SAMPLE_W(SAMPLE_W), .SCALE_W(SCALE_W), .OFFS_W(OFFS_W),
                      .ID_W(ID_W), .USER_W(USER_W)) dut_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .in_valid(in_valid), .in_sample(in_sample), .in_id(in_id), .in_user(in_user),
    .out_valid(out_valid), .out_value(out_value), .out_id(out_id), .out_user(out_user)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  int exp_v [64];
  int exp_id [64];
  int exp_u [64];
  int exp_c [64];
  logic [15:0] exp_t [64];
  int wr_n = 0;
  int rd_n = 0;
  int last_v = 0;
  int last_id = 0;
  int last_u = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, expv);
    end
  endtask

  // floor(s*g / 2^SCALE_W) + k, done with magnitude division
  function automatic int model(input int s, input int g, input int k);
    longint p;
    longint d;
    longint q;
    p = longint'(s) * longint'(g);
    d = longint'(1) << SCALE_W;
    if (p >= 0) q = p / d;
    else q = -((-p + d - 1) / d);
    return int'(q) + k;
  endfunction

  task automatic push(input logic [7:0] id, input logic [15:0] s, input logic [3:0] u,
                      input int ev, input logic [15:0] tag);
    in_valid = 1'b1; in_id = id; in_sample = s; in_user = u;
    exp_v[wr_n] = ev; exp_id[wr_n] = int'(id); exp_u[wr_n] = int'(u);
    exp_c[wr_n] = cyc + 3; exp_t[wr_n] = tag;
    wr_n++;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic cfg(input logic [7:0] a, input logic [31:0] w);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = w;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      if (out_valid) begin
        if (rd_n >= wr_n) begin
          chk(1'b0, "R2", int'(out_id), -1);
        end else begin
          chk(int'(out_value) == exp_v[rd_n], $sformatf("%s", exp_t[rd_n]), int'(out_value), exp_v[rd_n]);
          chk(int'(out_id) == exp_id[rd_n], "R3", int'(out_id), exp_id[rd_n]);
          chk(int'(out_user) == exp_u[rd_n], "R3", int'(out_user), exp_u[rd_n]);
          chk(cyc == exp_c[rd_n], "R2", cyc, exp_c[rd_n]);
          rd_n++;
        end
        last_v = int'(out_value); last_id = int'(out_id); last_u = int'(out_user);
      end else begin
        // R9: idle cycles keep the last result
        chk(int'(out_value) == last_v && int'(out_id) == last_id && int'(out_user) == last_u,
            "R9", int'(out_value), last_v);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog actual %0d expected %0d", cyc, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state at the ports
    chk(out_valid == 1'b0, "R1", longint'(out_valid), 0);
    chk(int'(out_value) == 0 && out_id == '0 && out_user == '0, "R1", int'(out_value), 0);
    rst = 1'b0;
    // R1: cleared table gives zero
    push(8'd5, 16'd20000, 4'd9, 0, "R1");
    push(8'd255, 16'h8000, 4'd2, 0, "R1");
    repeat (4) @(negedge clk);

    for (int i = 0; i < NV; i++) cfg(VECS[i].id, VECS[i].word);
    // R2: all vectors back to back
    for (int i = 0; i < NV; i++) push(VECS[i].id, VECS[i].smp, VECS[i].usr, VECS[i].ev, VECS[i].tag);
    repeat (5) @(negedge clk);

    // R8: write and sample on the same edge, then sample again
    cfg_we = 1'b1; cfg_addr = 8'd3; cfg_wdata = {4'h0, 12'd5, 16'h0000};
    push(8'd3, 16'd1000, 4'd1, 510, "R8");
    cfg_we = 1'b0;
    push(8'd3, 16'd1000, 4'd2, model(1000, 0, 5), "R8");
    // R6: other channels untouched by that write
    push(8'd7, -16'sd1000, 4'd3, model(-1000, 16'h4000, 0), "R6");
    push(8'd200, 16'd100, 4'd4, model(100, 16'hFFFF, -2048), "R6");
    // R5: model cross-check on a negative product
    push(8'd9, -16'sd7, 4'd5, model(-7, 16'h8000, 0), "R5");
    repeat (8) @(negedge clk);

    // R2: every input produced exactly one output
    chk(rd_n == wr_n, "R2", rd_n, wr_n);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule